// File: doc/BRIEF.md
# DMA Channel Request Scheduler

This block chooses, on every clock, which DMA channel is allowed to move its next single element. Each channel presents a 32-bit setup word and its remaining element count. Peripherals present a single-request and a burst-request line each. From these the scheduler works out which channels are ready and issues a registered one-hot grant with a valid strobe. The transfer engine consumes that grant.

A ready channel is enabled, not halted and has elements left. Its flow type must also be satisfied: memory-to-memory needs no request, and the peripheral flows need the source request, the destination request, or both. Once a channel holds the grant it keeps it for as long as it stays ready. When it drops out, the scan continues upward from the channel after it and wraps past the top. While the engine reports busy, the grant is frozen. A global enable turns the whole scheduler off. Flow types that need the peripheral to control the flow are not served, and they set a sticky flag.

Top module: `dma_grant_sched`

## Requirements
- R1: A channel can be granted only when bit 0 of its setup word (enable) is 1 and bit 18 (halt) is 0.
- R2: In the setup word, bits [13:11] hold the flow type, bits [5:1] the source peripheral number and bits [10:6] the destination peripheral number.
- R3: Flow type 0 (memory to memory) makes a channel ready without any peripheral request.
- R4: Flow type 1 needs the destination peripheral's request, flow type 2 the source peripheral's request, and flow type 3 both.
- R5: A peripheral's request is present when its single or its burst line is high. A peripheral number at or above NUM_PERIPH never has a request.
- R6: A channel whose remaining count is zero is never granted.
- R7: `grant_o` is one-hot or zero, and `grant_valid_o` is high exactly when it is nonzero. The grant reflects the inputs of the previous clock. Both are zero after reset.
- R8: A channel that holds the grant keeps it for as long as it remains ready, even when a lower-numbered channel is also ready.
- R9: When a new owner is chosen, it is the first ready channel found by scanning upward from the channel after the last owner, wrapping past the highest channel. After reset the scan starts at channel 0.
- R10: While `ctrl_enable_i` is 0, no grant is issued on the next clock, even when `engine_busy_i` is high.
- R11: While `engine_busy_i` is high and the controller is enabled, `grant_o` and `grant_valid_o` do not change.
- R12: A flow type from 4 to 7 never makes its channel ready. When that channel is also enabled, not halted and the controller is on, `unsup_flow_o` is set, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_enable_i | input | 1 | Global controller enable |
| ch_cfg_i | input | NUM_CH x 32 | Per-channel setup word |
| ch_count_i | input | NUM_CH x CNT_W | Per-channel remaining element count |
| req_single_i | input | NUM_PERIPH | Peripheral single requests |
| req_burst_i | input | NUM_PERIPH | Peripheral burst requests |
| engine_busy_i | input | 1 | Transfer engine busy; freezes the grant |
| grant_o | output | NUM_CH | One-hot grant |
| grant_valid_o | output | 1 | Grant present |
| unsup_flow_o | output | 1 | Sticky unsupported-flow flag |

## Verification
The in-design assertions check these properties on every clock:
- the grant is one-hot, and the valid strobe matches it;
- the grant is cleared after the controller has been disabled;
- the grant is frozen while the engine is busy;
- an owner that is still ready keeps the grant;
- no grant goes to a channel that was not ready;
- halted or empty channels are never marked ready;
- the unsupported-flow flag stays set once raised.

Only the bench scenarios can show that the setup fields, the request polarity and the flow-type decoding pick the intended peripherals. They also show which channel the wrapped upward scan chooses when ownership passes on.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  localparam int CFG_W = 32;

  localparam logic [2:0] FLOW_MEM2MEM = 3'd0;
  localparam logic [2:0] FLOW_TO_DST  = 3'd1;
  localparam logic [2:0] FLOW_FROM_SRC = 3'd2;
  localparam logic [2:0] FLOW_BOTH    = 3'd3;

  typedef struct packed {
    logic       on;
    logic       halt;
    logic [2:0] flow;
    logic [4:0] src_id;
    logic [4:0] dst_id;
  } chan_setup_t;

  // Field positions of the per-channel setup word.
  function automatic chan_setup_t decode_setup(input logic [CFG_W-1:0] w);
    chan_setup_t s;
    s.on     = w[0];
    s.halt   = w[18];
    s.flow   = w[13:11];
    s.src_id = w[5:1];
    s.dst_id = w[10:6];
    return s;
  endfunction

  // Request lookup; the vector is already zero above the peripheral count.
  function automatic logic periph_req(input logic [31:0] req_wide, input logic [4:0] id);
    return req_wide[id];
  endfunction

  function automatic logic flow_satisfied(input logic [2:0] flow, input logic src_req,
                                          input logic dst_req);
    logic ok;
    case (flow)
      FLOW_MEM2MEM:  ok = 1'b1;
      FLOW_TO_DST:   ok = dst_req;
      FLOW_FROM_SRC: ok = src_req;
      FLOW_BOTH:     ok = src_req & dst_req;
      default:       ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic flow_unsupported(input logic [2:0] flow);
    return flow[2];
  endfunction

endpackage

// File: rtl/dma_sched_elig.sv
module dma_sched_elig
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 16,
  parameter int CNT_W      = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CH-1:0][CFG_W-1:0]      cfg_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      count_i,
  input  logic [NUM_PERIPH-1:0]             req_any_i,
  output logic [NUM_CH-1:0]                 ready_o,
  output logic [NUM_CH-1:0]                 unsup_o
);

  logic [31:0] req_wide;
  assign req_wide = 32'(req_any_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_setup_t setup;
    logic        src_req;
    logic        dst_req;
    logic        candidate;
    logic        has_work;
    logic        unused_setup_bits;

    assign setup     = decode_setup(cfg_i[c]);
    assign src_req   = periph_req(req_wide, setup.src_id);
    assign dst_req   = periph_req(req_wide, setup.dst_id);
    assign candidate = setup.on & ~setup.halt;
    assign has_work  = |count_i[c];
    assign ready_o[c] = candidate & has_work & flow_satisfied(setup.flow, src_req, dst_req);
    assign unsup_o[c] = candidate & flow_unsupported(setup.flow);
    assign unused_setup_bits = ^{cfg_i[c][31:19], cfg_i[c][17:14]};

    // R1: a halted or disabled channel is never ready
    a_r1_halted_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_i[c][18] || !cfg_i[c][0]) |-> !ready_o[c]);
    // R6: an empty channel is never ready
    a_r6_empty_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i[c] == '0) |-> !ready_o[c]);
    // R12: upper flow types never ready
    a_r12_unsup_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_i[c][13] |-> !ready_o[c]);
  end

endmodule

// File: rtl/dma_sched_pick.sv
module dma_sched_pick #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] ready_i,
  input  logic [IDX_W-1:0]  last_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);

  // Scan upward from last_i+1, wrapping, last_i itself checked last.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      int j;
      j = (int'(last_i) + 1 + k) % NUM_CH;
      if (!found_o && ready_i[j]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/dma_grant_sched.sv
module dma_grant_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int NUM_PERIPH = 16,
  parameter int CNT_W      = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_enable_i,
  input  logic [NUM_CH-1:0][CFG_W-1:0]  ch_cfg_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_count_i,
  input  logic [NUM_PERIPH-1:0]         req_single_i,
  input  logic [NUM_PERIPH-1:0]         req_burst_i,
  input  logic                          engine_busy_i,
  output logic [NUM_CH-1:0]             grant_o,
  output logic                          grant_valid_o,
  output logic                          unsup_flow_o
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_PERIPH-1:0] req_any;
  logic [NUM_CH-1:0]     ready_vec;
  logic [NUM_CH-1:0]     unsup_vec;
  logic                  pick_found;
  logic [IDX_W-1:0]      pick_idx;

  logic [NUM_CH-1:0]     grant_q, grant_d;
  logic                  valid_q, valid_d;
  logic [IDX_W-1:0]      owner_q, owner_d;
  logic                  unsup_q;

  // Named events for the assertions
  logic owner_keeps;
  logic new_owner;

  assign req_any = req_single_i | req_burst_i;

  dma_sched_elig #(
    .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH), .CNT_W(CNT_W)
  ) u_elig (
    .clk(clk), .rst_n(rst_n),
    .cfg_i(ch_cfg_i), .count_i(ch_count_i), .req_any_i(req_any),
    .ready_o(ready_vec), .unsup_o(unsup_vec)
  );

  dma_sched_pick #(.NUM_CH(NUM_CH)) u_pick (
    .ready_i(ready_vec), .last_i(owner_q),
    .found_o(pick_found), .idx_o(pick_idx)
  );

  assign owner_keeps = valid_q & ready_vec[owner_q];
  assign new_owner   = ctrl_enable_i & ~engine_busy_i & ~owner_keeps & pick_found;

  always_comb begin
    grant_d = grant_q;
    valid_d = valid_q;
    owner_d = owner_q;
    if (!ctrl_enable_i) begin
      grant_d = '0;
      valid_d = 1'b0;
    end else if (engine_busy_i || owner_keeps) begin
      grant_d = grant_q;
    end else if (new_owner) begin
      grant_d = NUM_CH'(1) << pick_idx;
      valid_d = 1'b1;
      owner_d = pick_idx;
    end else begin
      grant_d = '0;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      valid_q <= 1'b0;
      owner_q <= IDX_W'(NUM_CH - 1);
      unsup_q <= 1'b0;
    end else begin
      grant_q <= grant_d;
      valid_q <= valid_d;
      owner_q <= owner_d;
      unsup_q <= unsup_q | (ctrl_enable_i & (|unsup_vec));
    end
  end

  assign grant_o       = grant_q;
  assign grant_valid_o = valid_q;
  assign unsup_flow_o  = unsup_q;

  // R7: one-hot grant and matching strobe
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o));
  a_r7_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o == (grant_o != '0));
  // R10: disabled controller yields no grant
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_enable_i |=> !grant_valid_o);
  // R11: busy freezes the grant
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_enable_i && engine_busy_i) |=> $stable(grant_o));
  // R8: a still-ready owner keeps the grant
  a_r8_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_enable_i && !engine_busy_i && grant_valid_o && |(grant_o & ready_vec))
      |=> $stable(grant_o));
  // R4: a fresh decision only grants a ready channel
  a_r4_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_enable_i && !engine_busy_i) |=> ((grant_o & ~$past(ready_vec)) == '0));
  // R12: the flag is sticky and set by an unsupported candidate
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_flow_o |=> unsup_flow_o);
  a_r12_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_enable_i && |unsup_vec) |=> unsup_flow_o);

endmodule

// File: tb/tb_dma_grant_sched.sv
`timescale 1ns/100ps
module tb_dma_grant_sched;

  localparam int NCH = 8;
  localparam int NP  = 16;
  localparam int CW  = 12;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   ctrl_enable;
  logic [NCH-1:0][31:0]   cfg;
  logic [NCH-1:0][CW-1:0] cnt;
  logic [NP-1:0]          rs, rb;
  logic                   busy;
  logic [NCH-1:0]         grant;
  logic                   gvalid;
  logic                   unsup;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dma_grant_sched #(.NUM_CH(NCH), .NUM_PERIPH(NP), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_enable_i(ctrl_enable),
    .ch_cfg_i(cfg), .ch_count_i(cnt),
    .req_single_i(rs), .req_burst_i(rb), .engine_busy_i(busy),
    .grant_o(grant), .grant_valid_o(gvalid), .unsup_flow_o(unsup)
  );

  // Setup word built from the field positions listed in R2 and R1
  function automatic logic [31:0] mk(input bit en, input bit halt, input int flow,
                                     input int src, input int dst);
    logic [31:0] w = '0;
    w[0]     = en;
    w[18]    = halt;
    w[13:11] = flow[2:0];
    w[5:1]   = src[4:0];
    w[10:6]  = dst[4:0];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctrl_enable = 1'b1; cfg = '0; cnt = '0; rs = '0; rb = '0; busy = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R7 reset grant", 32'(grant), 0);
    check("R7 reset valid", 32'(gvalid), 0);
    check("R12 reset flag", 32'(unsup), 0);
  endtask

  task automatic t_mem2mem();
    do_reset();
    cfg[2] = mk(1, 0, 0, 0, 0); cnt[2] = 5;
    step();
    check("R3 m2m grant", 32'(grant), 32'h4);
    check("R7 valid", 32'(gvalid), 1);
    cfg[2] = mk(1, 1, 0, 0, 0);
    step();
    check("R1 halted", 32'(grant), 0);
    cfg[2] = mk(1, 0, 0, 0, 0); cnt[2] = 0;
    step();
    check("R6 zero count", 32'(grant), 0);
    check("R7 valid low", 32'(gvalid), 0);
  endtask

  task automatic t_flows();
    do_reset();
    cfg[1] = mk(1, 0, 1, 3, 7); cnt[1] = 9;
    rs[6] = 1'b1;
    step();
    check("R2 wrong periph", 32'(grant), 0);
    rs = '0; rs[7] = 1'b1;
    step();
    check("R4 dst single", 32'(grant), 32'h2);
    rs = '0; rb[7] = 1'b1;
    step();
    check("R5 dst burst", 32'(grant), 32'h2);
    rb = '0;
    step();
    check("R4 no req", 32'(grant), 0);
    cfg[1] = mk(1, 0, 2, 3, 7); rs[7] = 1'b1;
    step();
    check("R4 src missing", 32'(grant), 0);
    rs = '0; rb[3] = 1'b1;
    step();
    check("R4 src burst", 32'(grant), 32'h2);
    cfg[1] = mk(1, 0, 3, 3, 9); rs = '0; rb = '0; rs[3] = 1'b1;
    step();
    check("R4 both missing dst", 32'(grant), 0);
    rs[9] = 1'b1;
    step();
    check("R4 both present", 32'(grant), 32'h2);
    cfg[1] = mk(1, 0, 2, 20, 0); rs = '1; rb = '1;
    step();
    check("R5 id beyond range", 32'(grant), 0);
  endtask

  task automatic t_ownership();
    do_reset();
    cfg[1] = mk(1, 0, 0, 0, 0); cnt[1] = 4;
    cfg[3] = mk(1, 0, 0, 0, 0); cnt[3] = 4;
    step();
    check("R9 first from ch0", 32'(grant), 32'h2);
    cfg[0] = mk(1, 0, 0, 0, 0); cnt[0] = 4;
    step();
    check("R8 keeps owner", 32'(grant), 32'h2);
    step();
    check("R8 keeps owner again", 32'(grant), 32'h2);
    cfg[1] = '0;
    step();
    check("R9 moves upward", 32'(grant), 32'h8);
    cfg[3] = '0;
    step();
    check("R9 wraps", 32'(grant), 32'h1);
  endtask

  task automatic t_busy();
    do_reset();
    cfg[2] = mk(1, 0, 0, 0, 0); cnt[2] = 2;
    step();
    check("R11 pre", 32'(grant), 32'h4);
    busy = 1'b1; cfg[2] = '0; cfg[4] = mk(1, 0, 0, 0, 0); cnt[4] = 2;
    step();
    check("R11 busy hold", 32'(grant), 32'h4);
    step();
    check("R11 busy hold 2", 32'(grant), 32'h4);
    busy = 1'b0;
    step();
    check("R9 after busy", 32'(grant), 32'h10);
  endtask

  task automatic t_enable();
    do_reset();
    ctrl_enable = 1'b0;
    cfg[0] = mk(1, 0, 0, 0, 0); cnt[0] = 3;
    step();
    check("R10 disabled", 32'(gvalid), 0);
    ctrl_enable = 1'b1;
    step();
    check("R10 enabled", 32'(grant), 32'h1);
    busy = 1'b1; ctrl_enable = 1'b0;
    step();
    check("R10 overrides busy", 32'(grant), 0);
  endtask

  task automatic t_unsupported();
    do_reset();
    cfg[5] = mk(1, 0, 5, 0, 0); cnt[5] = 3;
    step();
    check("R12 not granted", 32'(grant), 0);
    check("R12 flag set", 32'(unsup), 1);
    cfg[5] = '0; cfg[6] = mk(1, 0, 0, 0, 0); cnt[6] = 1;
    step();
    check("R12 flag sticky", 32'(unsup), 1);
    check("R12 others served", 32'(grant), 32'h40);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_mem2mem();
    t_flows();
    t_ownership();
    t_busy();
    t_enable();
    t_unsupported();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule